// File: doc/BRIEF.md
# Successive Approximation Data Register

This block is a nine-bit register with three roles in a 25-bit fixed-point signal datapath. The datapath can read it as a source operand and write it as a destination operand. Its bits drive the input bus of a digital-to-analog converter at all times. Analog-function commands also step it as a successive-approximation register, so that a comparator-driven search turns an analog input into a nine-bit code.

When the datapath writes the register, it takes the upper nine bits of the 25-bit result. When the datapath reads it, the nine bits sit in the most significant positions of the word and every lower position reads as one. This fill corrects the number-system offset of the conversion. One bit of the register, chosen by an index, is also presented as a condition bit for conditional arithmetic.

Each operation is a single-cycle command on plain pins. The register accepts one command every cycle and never stalls, so the block has no valid/ready handshake and no back-pressure. The analog comparator and the converter itself are outside the block.

Top module: `sar_data_reg`

## Requirements
- R1: After reset the register holds zero, so the DAC drive is 0 and the read word is 25'h00FFFF.
- R2: The read word always carries the register in bits 24:16 and ones in bits 15:0.
- R3: A datapath write stores write-data bits 24:16, and the new value is visible on the outputs in the cycle after the write edge.
- R4: The DAC drive always equals the register contents, the same bits that appear in read-word bits 24:16.
- R5: A start command with no write clears the register and sets bit 8 as the first trial bit (value 9'h100).
- R6: A step for bit k (k from 0 to 8) with no write or start keeps bit k when the comparator input is 1 (analog input at or above the DAC level) and clears bit k when it is 0.
- R7: A step for bit k with k above 0 sets bit k-1 as the next trial bit. A step for bit 0 sets no further bit.
- R8: A step whose bit index is 9 or more leaves the register unchanged.
- R9: A datapath write in the same cycle as a start or a step wins, and only the write data is stored.
- R10: A start in the same cycle as a step wins, and the result is 9'h100.
- R11: The test output shows register bit s for a test select s from 0 to 8, and shows 0 for s of 9 or more.
- R12: A step for bit k changes no bit other than bits k and k-1.
- R13: A start followed by steps for bits 8 down to 0, each step fed a comparator output that compares an input code with the DAC drive, leaves that input code in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Datapath write strobe |
| wr_data | input | 25 | Datapath result; bits 24:16 are stored |
| sar_start | input | 1 | Start a conversion |
| sar_step | input | 1 | Perform one approximation step |
| sar_bit_idx | input | 4 | Bit index for the step |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| test_sel | input | 4 | Bit index for the condition output |
| rd_data | output | 25 | Source operand word |
| dac_code | output | 9 | DAC input drive |
| test_bit | output | 1 | Selected register bit |

## Verification
A datapath write, a start command and an approximation step can all be requested in the same cycle, and the block has to resolve them by a fixed priority. The random stimulus raises the three strobes independently. This produces every overlap many times, together with out-of-range step indices. Directed cycles also pair a write with a step and a start with a step on purpose. After each edge, the DAC drive, the read word and the test bit are compared with a bench model that applies the write first, then the start, then the step. A full nine-step conversion against several input codes, including 0 and 511, checks the search as a whole.

// File: rtl/sar_reg_pkg.sv
package sar_reg_pkg;

  // Default geometry of the datapath word and the approximation register
  localparam int DEF_WORD_W = 25;
  localparam int DEF_REG_W  = 9;

  // Which source loads the register on a given edge
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STEP  = 2'd1,
    SRC_START = 2'd2,
    SRC_WRITE = 2'd3
  } load_src_e;

endpackage

// File: rtl/sar_step_unit.sv
// One approximation step: resolve the trial bit, seed the next lower trial bit
module sar_step_unit #(
  parameter int REG_W = 9,
  parameter int IDX_W = 4
) (
  input  logic [REG_W-1:0] cur_bits,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_hi,
  output logic [REG_W-1:0] next_bits,
  output logic             idx_ok
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_W);

  assign idx_ok = (bit_idx < LAST_IDX);

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_bit
      localparam logic [IDX_W-1:0] SELF_IDX  = IDX_W'(gi);
      localparam logic [IDX_W-1:0] ABOVE_IDX = IDX_W'(gi + 1);
      logic is_trial;
      logic is_next;
      assign is_trial = idx_ok && (bit_idx == SELF_IDX);
      assign is_next  = idx_ok && (bit_idx == ABOVE_IDX);
      always_comb begin
        if (is_trial)      next_bits[gi] = cur_bits[gi] & cmp_hi;
        else if (is_next)  next_bits[gi] = 1'b1;
        else               next_bits[gi] = cur_bits[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/sar_bit_tap.sv
// Presents one register bit as a condition flag; out-of-range select yields 0
module sar_bit_tap #(
  parameter int REG_W = 9,
  parameter int IDX_W = 4
) (
  input  logic [REG_W-1:0] reg_bits,
  input  logic [IDX_W-1:0] sel,
  output logic             flag
);

  logic [REG_W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_tap
      assign hit[gi] = reg_bits[gi] && (sel == IDX_W'(gi));
    end
  endgenerate

  assign flag = |hit;

endmodule

// File: rtl/sar_word_pack.sv
// Places the register at the top of the datapath word, fills the rest with ones
module sar_word_pack #(
  parameter int WORD_W = 25,
  parameter int REG_W  = 9
) (
  input  logic [REG_W-1:0]  reg_bits,
  output logic [WORD_W-1:0] word
);

  localparam int PAD_W = WORD_W - REG_W;

  assign word = {reg_bits, {PAD_W{1'b1}}};

endmodule

// File: rtl/sar_data_reg.sv
module sar_data_reg
  import sar_reg_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int REG_W  = DEF_REG_W,
  localparam int IDX_W = $clog2(REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sar_start,
  input  logic              sar_step,
  input  logic [IDX_W-1:0]  sar_bit_idx,
  input  logic              cmp_hi,
  input  logic [IDX_W-1:0]  test_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [REG_W-1:0]  dac_code,
  output logic              test_bit
);

  localparam int PAD_W = WORD_W - REG_W;
  localparam logic [REG_W-1:0] FIRST_TRIAL = {1'b1, {(REG_W-1){1'b0}}};

  logic [REG_W-1:0] sar_q;
  logic [REG_W-1:0] sar_d;
  logic [REG_W-1:0] stepped;
  logic             step_idx_ok;
  load_src_e        src;

  logic unused_low_bits;
  assign unused_low_bits = ^wr_data[PAD_W-1:0];

  sar_step_unit #(.REG_W(REG_W), .IDX_W(IDX_W)) u_step (
    .cur_bits (sar_q),
    .bit_idx  (sar_bit_idx),
    .cmp_hi   (cmp_hi),
    .next_bits(stepped),
    .idx_ok   (step_idx_ok)
  );

  // Priority: datapath write, then start, then step
  always_comb begin
    if (wr_en)                          src = SRC_WRITE;
    else if (sar_start)                 src = SRC_START;
    else if (sar_step && step_idx_ok)   src = SRC_STEP;
    else                                src = SRC_HOLD;
  end

  always_comb begin
    case (src)
      SRC_WRITE: sar_d = wr_data[WORD_W-1:PAD_W];
      SRC_START: sar_d = FIRST_TRIAL;
      SRC_STEP:  sar_d = stepped;
      default:   sar_d = sar_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sar_q <= '0;
    else        sar_q <= sar_d;
  end

  assign dac_code = sar_q;

  sar_word_pack #(.WORD_W(WORD_W), .REG_W(REG_W)) u_pack (
    .reg_bits(sar_q),
    .word    (rd_data)
  );

  sar_bit_tap #(.REG_W(REG_W), .IDX_W(IDX_W)) u_tap (
    .reg_bits(sar_q),
    .sel     (test_sel),
    .flag    (test_bit)
  );

endmodule

// File: rtl/sar_data_reg_chk.sv
module sar_data_reg_chk #(
  parameter int WORD_W = 25,
  parameter int REG_W  = 9,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              sar_start,
  input logic              sar_step,
  input logic [IDX_W-1:0]  sar_bit_idx,
  input logic              cmp_hi,
  input logic [IDX_W-1:0]  test_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic [REG_W-1:0]  dac_code,
  input logic              test_bit
);

  localparam int PAD_W = WORD_W - REG_W;
  localparam logic [IDX_W-1:0] LIM = IDX_W'(REG_W);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (dac_code == '0));

  assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PAD_W-1:0] == {PAD_W{1'b1}});

  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (dac_code == $past(wr_data[WORD_W-1:PAD_W])));

  assert_dac_matches_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_code == rd_data[WORD_W-1:PAD_W]);

  assert_start_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sar_start) |=> (dac_code == {1'b1, {(REG_W-1){1'b0}}}));

  assert_step_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sar_start && sar_step && (sar_bit_idx < LIM) && !cmp_hi)
      |=> (dac_code[$past(sar_bit_idx)] == 1'b0));

  assert_step_bad_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sar_start && sar_step && (sar_bit_idx >= LIM))
      |=> (dac_code == $past(dac_code)));

  assert_tap_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel >= LIM) |-> !test_bit);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sar_start && !sar_step) |=> $stable(dac_code));

endmodule

bind sar_data_reg sar_data_reg_chk #(.WORD_W(WORD_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .sar_start(sar_start), .sar_step(sar_step), .sar_bit_idx(sar_bit_idx),
  .cmp_hi(cmp_hi), .test_sel(test_sel), .rd_data(rd_data),
  .dac_code(dac_code), .test_bit(test_bit)
);

// File: tb/sar_data_reg_tb.sv
`timescale 1ns/1ps
module sar_data_reg_tb;

  localparam int WORD_W = 25;
  localparam int REG_W  = 9;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic              sar_start;
  logic              sar_step;
  logic [IDX_W-1:0]  sar_bit_idx;
  logic              cmp_hi;
  logic [IDX_W-1:0]  test_sel;
  logic [WORD_W-1:0] rd_data;
  logic [REG_W-1:0]  dac_code;
  logic              test_bit;

  int checks = 0;
  int errors = 0;
  logic [REG_W-1:0] exp_reg;

  always #2 clk = ~clk;

  sar_data_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sar_start(sar_start), .sar_step(sar_step), .sar_bit_idx(sar_bit_idx),
    .cmp_hi(cmp_hi), .test_sel(test_sel), .rd_data(rd_data),
    .dac_code(dac_code), .test_bit(test_bit)
  );

  function automatic logic [REG_W-1:0] model_next(
    input logic [REG_W-1:0] cur, input logic wr, input logic [WORD_W-1:0] wd,
    input logic st, input logic sp, input logic [IDX_W-1:0] idx, input logic cmp);
    logic [REG_W-1:0] n;
    if (wr) return wd[WORD_W-1:WORD_W-REG_W];
    if (st) return 9'h100;
    n = cur;
    if (sp && idx <= 4'd8) begin
      if (!cmp) n[idx] = 1'b0;
      if (idx != 4'd0) n[idx - 4'd1] = 1'b1;
    end
    return n;
  endfunction

  function automatic logic exp_tap(input logic [REG_W-1:0] r, input logic [IDX_W-1:0] s);
    return (s <= 4'd8) ? r[s] : 1'b0;
  endfunction

  task automatic check_all(input string tag);
    checks++;
    if (dac_code !== exp_reg) begin
      errors++;
      $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, exp_reg);
    end
    checks++;
    if (rd_data !== {exp_reg, 16'hFFFF}) begin
      errors++;
      $display("FAIL R2 %s rd_data actual=%h expected=%h", tag, rd_data, {exp_reg, 16'hFFFF});
    end
    checks++;
    if (test_bit !== exp_tap(exp_reg, test_sel)) begin
      errors++;
      $display("FAIL R11 %s test_bit actual=%b expected=%b sel=%0d", tag, test_bit,
               exp_tap(exp_reg, test_sel), test_sel);
    end
  endtask

  // Drive at negedge, apply one edge, check 1 ns after it
  task automatic cycle(input logic wr, input logic [WORD_W-1:0] wd, input logic st,
                       input logic sp, input logic [IDX_W-1:0] idx, input logic cmp,
                       input logic [IDX_W-1:0] sel, input string tag);
    @(negedge clk);
    wr_en = wr; wr_data = wd; sar_start = st; sar_step = sp;
    sar_bit_idx = idx; cmp_hi = cmp; test_sel = sel;
    @(posedge clk);
    exp_reg = model_next(exp_reg, wr, wd, st, sp, idx, cmp);
    #1;
    check_all(tag);
  endtask

  task automatic convert(input logic [REG_W-1:0] vin);
    cycle(1'b0, '0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd8, "R5 start");
    for (int k = 8; k >= 0; k--) begin
      cycle(1'b0, '0, 1'b0, 1'b1, IDX_W'(k), (vin >= dac_code), IDX_W'(k), "R6 R7 step");
    end
    checks++;
    if (dac_code !== vin) begin
      errors++;
      $display("FAIL R13 conversion actual=%h expected=%h", dac_code, vin);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_data = '0; sar_start = 0; sar_step = 0;
    sar_bit_idx = '0; cmp_hi = 0; test_sel = '0;
    exp_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_all("R1 reset");
    checks++;
    if (rd_data !== 25'h00FFFF) begin
      errors++;
      $display("FAIL R1 rd_data actual=%h expected=%h", rd_data, 25'h00FFFF);
    end

    // Directed corner cases
    cycle(1'b1, 25'h1ABCDEF, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8, "R3 write");
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd9, 1'b0, 4'd3, "R8 idx 9");
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd15, 1'b1, 4'd15, "R8 idx 15");
    cycle(1'b1, 25'h0123456, 1'b1, 1'b1, 4'd4, 1'b0, 4'd1, "R9 write vs start/step");
    cycle(1'b1, 25'h1FFFFFF, 1'b0, 1'b1, 4'd8, 1'b0, 4'd0, "R9 write vs step");
    cycle(1'b0, '0, 1'b1, 1'b1, 4'd8, 1'b0, 4'd8, "R10 start vs step");
    cycle(1'b1, 25'h0000000, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R3 write zero");
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd0, 1'b1, 4'd0, "R7 step bit0 keeps");
    cycle(1'b1, 25'h1550000, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2, "R3 write pattern");
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd4, 1'b0, 4'd3, "R12 step mid");
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, "R7 step bit0 clears");

    convert(9'd0);
    convert(9'd511);
    convert(9'd256);
    convert(9'd255);
    convert(9'h0A5);

    // Constrained random mix with deliberate overlaps
    for (int n = 0; n < 3000; n++) begin
      logic wr, st, sp;
      logic [IDX_W-1:0] idx, sel;
      wr  = ($urandom_range(0, 5) == 0);
      st  = ($urandom_range(0, 7) == 0);
      sp  = ($urandom_range(0, 1) == 1);
      idx = IDX_W'($urandom_range(0, 11));
      sel = IDX_W'($urandom_range(0, 15));
      cycle(wr, WORD_W'($urandom), st, sp, idx, 1'($urandom), sel,
            wr ? "R3 R9 random" : (st ? "R5 R10 random" : "R4 R6 R12 random"));
    end

    for (int v = 0; v < 20; v++) convert(REG_W'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule